// File: doc/BRIEF.md
# Cache Line Write-Policy State Controller

This block keeps the coherence state (invalid, shared, exclusive, modified) of every line in a small data cache. Each line's state sits in its own register. The block watches bus cycles that the surrounding bus engine presents as simple strobes. It samples an external policy input, where high means writeback and low means writethrough, together with the page writethrough attribute of the cycle. From these it decides whether a filled line, or a shared line written through the bus, ends up shared or exclusive. A write hit to an exclusive line is promoted to modified and stays on chip. A write hit to a shared line raises a request for an external write.

A maintenance engine serves inquire and snoop requests, and also a full flush, which covers writeback-and-invalidate. Every writeback the engine needs leaves through a valid/ready stream that carries the line index. When the stream sink holds `wb_ready` low, the engine stalls. `wb_valid` and `wb_idx` then stay unchanged until a cycle in which both valid and ready are high, and that cycle completes the transfer. Inquires are accepted through `inq_valid`/`inq_ready`. Ready is high only while the engine is idle and no flush is being started. Bus strobes, write hits and the probe port are plain signals. The bus engine keeps bus cycles, write hits and maintenance work apart in time.

Top module: `line_policy_ctrl`

## Requirements
- R1: After reset every line reads invalid on `rd_state` (encoding invalid=0, shared=1, exclusive=2, modified=3), and `wb_valid`, `ext_write` and `flush_done` are low.
- R2: A fill cycle (`cyc_kind`=0) ends after four `brdy` strobes. If the captured policy is high and `cyc_pwt` is low, the line ends exclusive.
- R3: A fill in which the captured policy is low or `cyc_pwt` is high leaves the line shared.
- R4: The policy input is captured only at the first `brdy` or `na` strobe of a cycle. Its value at later strobes of the same cycle has no effect.
- R5: Writeback-write cycles (`cyc_kind`=2) and other cycles (`cyc_kind`=3) leave every line state unchanged, whatever the policy input does.
- R6: A writethrough-write cycle (`cyc_kind`=1) ends on its first `brdy`. When the addressed line is shared, the line goes exclusive if the policy is high and `cyc_pwt` is low, and otherwise stays shared. A line in any other state is left unchanged.
- R7: A write hit to an exclusive line makes it modified without `ext_write`. A write hit to a modified line keeps it modified without `ext_write`.
- R8: A write hit to a shared line pulses `ext_write`, with `ext_idx` equal to the line, in the cycle after the hit. The line stays shared.
- R9: An inquire without invalidate on a modified line issues one writeback of that line and then leaves it shared. On an exclusive line it gives shared with no writeback.
- R10: An inquire with invalidate leaves a valid line invalid. It first issues a writeback only when the line was modified.
- R11: `wb_valid` and `wb_idx` hold steady until `wb_ready` is seen. `inq_ready` is low while a writeback is pending or a flush runs.
- R12: A flush issues one writeback per modified line in ascending index order. It then invalidates every line and pulses `flush_done` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Start of a bus cycle |
| cyc_kind | input | 2 | 0 fill, 1 writethrough write, 2 writeback write, 3 other |
| cyc_idx | input | IDX_W | Line addressed by the cycle |
| cyc_pwt | input | 1 | Page writethrough attribute |
| brdy | input | 1 | Data ready strobe |
| na | input | 1 | Next-address strobe |
| wbwt_in | input | 1 | Policy input: 1 writeback, 0 writethrough |
| wr_hit | input | 1 | Core write hit strobe |
| wr_idx | input | IDX_W | Line hit by the write |
| ext_write | output | 1 | Write must go out on the bus |
| ext_idx | output | IDX_W | Line of that external write |
| inq_valid | input | 1 | Inquire or snoop request |
| inq_ready | output | 1 | Inquire accepted |
| inq_idx | input | IDX_W | Line inquired |
| inq_inv | input | 1 | Invalidate on inquire |
| flush_start | input | 1 | Start flush or writeback-and-invalidate |
| flush_done | output | 1 | Flush finished pulse |
| wb_valid | output | 1 | Writeback request valid |
| wb_ready | input | 1 | Writeback request taken |
| wb_idx | output | IDX_W | Line to write back |
| rd_idx | input | IDX_W | Probe line select |
| rd_state | output | 2 | Probe line state |

## Verification
Fills are run with the policy and page attribute in all four combinations, so that the exclusive outcome is told apart from the shared ones. Some fills deliver their first strobe as `na` and others as `brdy`, and in each the policy input is flipped on the later beats, which shows whether capture happens at the right strobe. The policy is also set high during writeback-write and other cycles, and during writethrough writes to lines that are not shared, to expose any sampling in the wrong cycle types. Random mixes of write hits, inquires with random sink stalls, and flushes over varied sets of modified lines check the writeback order, the count and the held stream values against a line-state model kept in the bench.

// File: rtl/lpc_pkg.sv
`timescale 1ns/1ps
package lpc_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2,
    LN_MOD = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    CY_FILL  = 2'd0,
    CY_WTWR  = 2'd1,
    CY_WBWR  = 2'd2,
    CY_OTHER = 2'd3
  } cyc_kind_t;

  typedef struct packed {
    logic      vld;
    cyc_kind_t kind;
    logic      excl;
  } bus_ev_t;
endpackage

// File: rtl/lpc_bus_sampler.sv
`timescale 1ns/1ps
module lpc_bus_sampler
  import lpc_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int BEATS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic [1:0]       cyc_kind,
  input  logic [IDX_W-1:0] cyc_idx,
  input  logic             cyc_pwt,
  input  logic             brdy,
  input  logic             na,
  input  logic             pol_in,
  output bus_ev_t          ev,
  output logic [IDX_W-1:0] ev_idx
);
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  logic             open_q, seen_q, pol_q, pwt_q;
  cyc_kind_t        kind_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] beat_q;

  logic first_strobe, samp_type, eff_pol, last_beat;

  always_comb begin
    first_strobe = open_q && (brdy || na) && !seen_q;
    samp_type    = (kind_q == CY_FILL) || (kind_q == CY_WTWR);
    // the policy seen at the first strobe wins; later values do not count
    eff_pol      = seen_q ? pol_q : pol_in;
    last_beat    = open_q && brdy && ((kind_q != CY_FILL) || (beat_q == LAST_BEAT));
    ev.vld       = last_beat;
    ev.kind      = kind_q;
    ev.excl      = samp_type && eff_pol && !pwt_q;
    ev_idx       = idx_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      seen_q <= 1'b0;
      pol_q  <= 1'b0;
      pwt_q  <= 1'b0;
      kind_q <= CY_OTHER;
      idx_q  <= '0;
      beat_q <= '0;
    end else if (cyc_start) begin
      open_q <= 1'b1;
      seen_q <= 1'b0;
      kind_q <= cyc_kind_t'(cyc_kind);
      idx_q  <= cyc_idx;
      pwt_q  <= cyc_pwt;
      beat_q <= '0;
    end else begin
      if (first_strobe) begin
        seen_q <= 1'b1;
        if (samp_type) pol_q <= pol_in;
      end
      if (open_q && brdy) beat_q <= beat_q + CNT_W'(1);
      if (last_beat) open_q <= 1'b0;
    end
  end

  AST_NO_CYC_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> !open_q) else $error("bus cycle started while one is open"); // R4
  AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && seen_q && !cyc_start) |=> $stable(pol_q)) else $error("policy changed after capture"); // R4
endmodule

// File: rtl/lpc_line_array.sv
`timescale 1ns/1ps
module lpc_line_array
  import lpc_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  bus_ev_t                ev,
  input  logic [IDX_W-1:0]       ev_idx,
  input  logic                   flush_clr,
  input  logic                   inq_upd,
  input  logic [IDX_W-1:0]       inq_upd_idx,
  input  line_st_t               inq_new,
  input  logic                   wr_hit,
  input  logic [IDX_W-1:0]       wr_idx,
  output line_st_t [LINES-1:0]   st_o,
  output logic                   ext_write,
  output logic [IDX_W-1:0]       ext_idx
);
  line_st_t st_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t nx;
    logic     ev_here, inq_here, wr_here;
    always_comb begin
      ev_here  = ev.vld && (ev_idx == IDX_W'(g));
      inq_here = inq_upd && (inq_upd_idx == IDX_W'(g));
      wr_here  = wr_hit && (wr_idx == IDX_W'(g));
      nx = st_q[g];
      if (flush_clr)
        nx = LN_INV;
      else if (inq_here)
        nx = inq_new;
      else if (ev_here && (ev.kind == CY_FILL || (ev.kind == CY_WTWR && st_q[g] == LN_SHR)))
        nx = ev.excl ? LN_EXC : LN_SHR;
      else if (wr_here && st_q[g] == LN_EXC)
        nx = LN_MOD;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) st_q[g] <= LN_INV;
      else        st_q[g] <= nx;
    end
    assign st_o[g] = st_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_write <= 1'b0;
      ext_idx   <= '0;
    end else begin
      ext_write <= wr_hit && (st_o[wr_idx] == LN_SHR);
      ext_idx   <= wr_idx;
    end
  end

  logic any_live;
  always_comb begin
    any_live = 1'b0;
    for (int i = 0; i < LINES; i++) if (st_q[i] != LN_INV) any_live = 1'b1;
  end

  AST_EXC_TO_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && st_o[wr_idx] == LN_EXC && !flush_clr && !inq_upd && !ev.vld)
    |=> st_o[$past(wr_idx)] == LN_MOD) else $error("exclusive write hit not promoted"); // R7
  AST_FLUSH_ALL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    flush_clr |=> !any_live) else $error("line valid after flush"); // R12
  AST_FILL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.vld && ev.kind == CY_FILL && !flush_clr && !inq_upd)
    |=> st_o[$past(ev_idx)] != LN_INV) else $error("fill left line invalid"); // R2
  AST_SHR_WRITE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ext_write |-> !$past(flush_clr)) else $error("external write during flush clear"); // R8
endmodule

// File: rtl/lpc_maint_engine.sv
`timescale 1ns/1ps
module lpc_maint_engine
  import lpc_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  line_st_t [LINES-1:0] st_i,
  input  logic                 flush_start,
  input  logic                 inq_valid,
  input  logic [IDX_W-1:0]     inq_idx,
  input  logic                 inq_inv,
  output logic                 inq_ready,
  output logic                 wb_valid,
  output logic [IDX_W-1:0]     wb_idx,
  input  logic                 wb_ready,
  output logic                 inq_upd,
  output logic [IDX_W-1:0]     inq_upd_idx,
  output line_st_t             inq_new,
  output logic                 flush_clr,
  output logic                 flush_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  typedef enum logic [2:0] {E_IDLE, E_IWB, E_SCAN, E_FWB, E_CLR} eng_t;

  eng_t             cur_q, nxt;
  logic [IDX_W-1:0] ptr_q, ptr_d, qidx_q, qidx_d;
  logic             qinv_q, qinv_d;

  always_comb begin
    nxt         = cur_q;
    ptr_d       = ptr_q;
    qidx_d      = qidx_q;
    qinv_d      = qinv_q;
    inq_ready   = 1'b0;
    wb_valid    = 1'b0;
    wb_idx      = ptr_q;
    inq_upd     = 1'b0;
    inq_upd_idx = inq_idx;
    inq_new     = LN_INV;
    flush_clr   = 1'b0;
    flush_done  = 1'b0;
    unique case (cur_q)
      E_IDLE: begin
        inq_ready = !flush_start;
        if (flush_start) begin
          nxt   = E_SCAN;
          ptr_d = '0;
        end else if (inq_valid) begin
          qidx_d = inq_idx;
          qinv_d = inq_inv;
          if (st_i[inq_idx] == LN_MOD) begin
            nxt = E_IWB;
          end else begin
            inq_upd     = (st_i[inq_idx] != LN_INV);
            inq_upd_idx = inq_idx;
            inq_new     = inq_inv ? LN_INV : LN_SHR;
          end
        end
      end
      E_IWB: begin
        wb_valid = 1'b1;
        wb_idx   = qidx_q;
        if (wb_ready) begin
          inq_upd     = 1'b1;
          inq_upd_idx = qidx_q;
          inq_new     = qinv_q ? LN_INV : LN_SHR;
          nxt         = E_IDLE;
        end
      end
      E_SCAN: begin
        if (st_i[ptr_q] == LN_MOD) nxt = E_FWB;
        else if (ptr_q == LAST)    nxt = E_CLR;
        else                       ptr_d = ptr_q + IDX_W'(1);
      end
      E_FWB: begin
        wb_valid = 1'b1;
        wb_idx   = ptr_q;
        if (wb_ready) begin
          if (ptr_q == LAST) nxt = E_CLR;
          else begin
            ptr_d = ptr_q + IDX_W'(1);
            nxt   = E_SCAN;
          end
        end
      end
      E_CLR: begin
        flush_clr  = 1'b1;
        flush_done = 1'b1;
        nxt        = E_IDLE;
      end
      default: nxt = E_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= E_IDLE;
      ptr_q  <= '0;
      qidx_q <= '0;
      qinv_q <= 1'b0;
    end else begin
      cur_q  <= nxt;
      ptr_q  <= ptr_d;
      qidx_q <= qidx_d;
      qinv_q <= qinv_d;
    end
  end

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_idx))) else $error("writeback request dropped"); // R11
  AST_WB_ONLY_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> st_i[wb_idx] == LN_MOD) else $error("writeback of a clean line"); // R9
  AST_INQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    inq_ready |-> !wb_valid) else $error("inquire accepted while busy"); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done) else $error("done pulse too long"); // R12
endmodule

// File: rtl/line_policy_ctrl.sv
`timescale 1ns/1ps
module line_policy_ctrl
  import lpc_pkg::*;
#(
  parameter int LINES = 8,
  parameter int BEATS = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic [1:0]       cyc_kind,
  input  logic [IDX_W-1:0] cyc_idx,
  input  logic             cyc_pwt,
  input  logic             brdy,
  input  logic             na,
  input  logic             wbwt_in,
  input  logic             wr_hit,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             ext_write,
  output logic [IDX_W-1:0] ext_idx,
  input  logic             inq_valid,
  output logic             inq_ready,
  input  logic [IDX_W-1:0] inq_idx,
  input  logic             inq_inv,
  input  logic             flush_start,
  output logic             flush_done,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [IDX_W-1:0] wb_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_state
);
  bus_ev_t              ev;
  logic [IDX_W-1:0]     ev_idx;
  line_st_t [LINES-1:0] st_vec;
  logic                 inq_upd, flush_clr;
  logic [IDX_W-1:0]     inq_upd_idx;
  line_st_t             inq_new;

  lpc_bus_sampler #(.IDX_W(IDX_W), .BEATS(BEATS)) u_samp (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_kind(cyc_kind),
    .cyc_idx(cyc_idx), .cyc_pwt(cyc_pwt), .brdy(brdy), .na(na),
    .pol_in(wbwt_in), .ev(ev), .ev_idx(ev_idx)
  );

  lpc_line_array #(.LINES(LINES), .IDX_W(IDX_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ev_idx(ev_idx), .flush_clr(flush_clr),
    .inq_upd(inq_upd), .inq_upd_idx(inq_upd_idx), .inq_new(inq_new),
    .wr_hit(wr_hit), .wr_idx(wr_idx), .st_o(st_vec),
    .ext_write(ext_write), .ext_idx(ext_idx)
  );

  lpc_maint_engine #(.LINES(LINES), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .st_i(st_vec), .flush_start(flush_start),
    .inq_valid(inq_valid), .inq_idx(inq_idx), .inq_inv(inq_inv),
    .inq_ready(inq_ready), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_ready(wb_ready), .inq_upd(inq_upd), .inq_upd_idx(inq_upd_idx),
    .inq_new(inq_new), .flush_clr(flush_clr), .flush_done(flush_done)
  );

  assign rd_state = st_vec[rd_idx];
endmodule

// File: tb/line_policy_ctrl_test.sv
`timescale 1ns/1ps
module line_policy_ctrl_test;
  localparam int LINES = 8;
  localparam int IW = 3;
  localparam int INV = 0, SHR = 1, EXC = 2, MOD = 3;

  logic clk = 0, rst_n = 0;
  logic cyc_start = 0, cyc_pwt = 0, brdy = 0, na = 0, wbwt_in = 0;
  logic [1:0] cyc_kind = 0;
  logic [IW-1:0] cyc_idx = 0, wr_idx = 0, inq_idx = 0, rd_idx = 0;
  logic wr_hit = 0, inq_valid = 0, inq_inv = 0, flush_start = 0, wb_ready = 0;
  logic ext_write, inq_ready, flush_done, wb_valid;
  logic [IW-1:0] ext_idx, wb_idx;
  logic [1:0] rd_state;

  int total = 0, bad = 0;
  int model [LINES];

  line_policy_ctrl #(.LINES(LINES), .BEATS(4)) uut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_kind(cyc_kind),
    .cyc_idx(cyc_idx), .cyc_pwt(cyc_pwt), .brdy(brdy), .na(na), .wbwt_in(wbwt_in),
    .wr_hit(wr_hit), .wr_idx(wr_idx), .ext_write(ext_write), .ext_idx(ext_idx),
    .inq_valid(inq_valid), .inq_ready(inq_ready), .inq_idx(inq_idx), .inq_inv(inq_inv),
    .flush_start(flush_start), .flush_done(flush_done), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_idx(wb_idx), .rd_idx(rd_idx), .rd_state(rd_state)
  );

  always #2 clk = ~clk;

  function automatic int policy_state(bit pol, bit pwt);
    return (pol && !pwt) ? EXC : SHR;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < LINES; i++) begin
      rd_idx = IW'(i);
      #0.1;
      chk(int'(rd_state) == model[i], req, rd_state, model[i]);
    end
  endtask

  // fill: four brdy beats; first strobe may be na; policy flipped after capture
  task automatic do_fill(int idx, bit pol, bit pwt, bit use_na, string req);
    @(negedge clk);
    cyc_start = 1; cyc_kind = 2'd0; cyc_idx = IW'(idx); cyc_pwt = pwt;
    @(negedge clk);
    cyc_start = 0;
    if (use_na) begin
      na = 1; wbwt_in = pol;
      @(negedge clk);
      na = 0;
    end
    for (int b = 0; b < 4; b++) begin
      brdy = 1;
      wbwt_in = (b == 0 && !use_na) ? pol : !pol;
      @(negedge clk);
    end
    brdy = 0; wbwt_in = 0;
    model[idx] = policy_state(pol, pwt);
    check_all(req);
  endtask

  task automatic do_buswr(int kind, int idx, bit pol, bit pwt, string req);
    @(negedge clk);
    cyc_start = 1; cyc_kind = 2'(kind); cyc_idx = IW'(idx); cyc_pwt = pwt;
    @(negedge clk);
    cyc_start = 0; brdy = 1; wbwt_in = pol;
    @(negedge clk);
    brdy = 0; wbwt_in = !pol;
    if (kind == 1 && model[idx] == SHR) model[idx] = policy_state(pol, pwt);
    check_all(req);
    wbwt_in = 0;
  endtask

  task automatic do_wrhit(int idx);
    @(negedge clk);
    wr_hit = 1; wr_idx = IW'(idx);
    @(negedge clk);
    wr_hit = 0;
    chk(ext_write == (model[idx] == SHR), "R8 ext_write", ext_write, model[idx] == SHR);
    if (model[idx] == SHR) chk(int'(ext_idx) == idx, "R8 ext_idx", ext_idx, idx);
    if (model[idx] == EXC) model[idx] = MOD;
    check_all("R7");
  endtask

  task automatic do_inq(int idx, bit inv, int stall);
    bit was_mod = (model[idx] == MOD);
    @(negedge clk);
    inq_valid = 1; inq_idx = IW'(idx); inq_inv = inv;
    chk(inq_ready == 1, "R11 idle ready", inq_ready, 1);
    @(negedge clk);
    inq_valid = 0;
    chk(wb_valid == was_mod, inv ? "R10 wb" : "R9 wb", wb_valid, was_mod);
    if (was_mod) begin
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(wb_valid && int'(wb_idx) == idx, "R11 hold", wb_idx, idx);
        chk(inq_ready == 0, "R11 busy", inq_ready, 0);
      end
      chk(int'(wb_idx) == idx, inv ? "R10 idx" : "R9 idx", wb_idx, idx);
      wb_ready = 1;
      @(negedge clk);
      wb_ready = 0;
      chk(wb_valid == 0, "R11 release", wb_valid, 0);
    end
    if (model[idx] != INV) model[idx] = inv ? INV : SHR;
    check_all(inv ? "R10" : "R9");
  endtask

  task automatic do_flush();
    int exp_list [LINES];
    int ne = 0, n = 0, guard = 0;
    bit done = 0;
    for (int i = 0; i < LINES; i++) if (model[i] == MOD) begin exp_list[ne] = i; ne++; end
    @(negedge clk);
    flush_start = 1;
    @(negedge clk);
    flush_start = 0;
    chk(inq_ready == 0, "R11 flush busy", inq_ready, 0);
    while (!done && guard < 400) begin
      guard++;
      if (flush_done) done = 1;
      else begin
        bit r = 1'($urandom % 2);
        wb_ready = r;
        if (wb_valid && r) begin
          if (n < ne) chk(int'(wb_idx) == exp_list[n], "R12 order", wb_idx, exp_list[n]);
          n++;
        end
        @(negedge clk);
      end
    end
    wb_ready = 0;
    chk(done, "R12 done seen", done, 1);
    chk(n == ne, "R12 wb count", n, ne);
    @(negedge clk);
    chk(flush_done == 0, "R12 pulse", flush_done, 0);
    for (int i = 0; i < LINES; i++) model[i] = INV;
    check_all("R12");
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < LINES; i++) model[i] = INV;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_all("R1");
    chk(wb_valid == 0, "R1 wb_valid", wb_valid, 0);
    chk(ext_write == 0, "R1 ext_write", ext_write, 0);
    chk(flush_done == 0, "R1 flush_done", flush_done, 0);

    // R2 / R3 all four policy combinations
    do_fill(0, 1, 0, 0, "R2");
    do_fill(1, 0, 0, 0, "R3");
    do_fill(2, 1, 1, 0, "R3");
    do_fill(3, 0, 1, 0, "R3");
    // R4 na first: pin high at na, low on all beats
    do_fill(4, 1, 0, 1, "R4");
    // R4 na first: pin low at na, high on all beats
    do_fill(5, 0, 0, 1, "R4");
    // R5 ignored cycle types with policy high on shared line 1
    do_buswr(2, 1, 1, 0, "R5");
    do_buswr(3, 1, 1, 0, "R5");
    // R6 writethrough write: shared -> exclusive; exclusive left alone with pol low
    do_buswr(1, 1, 1, 0, "R6");
    do_buswr(1, 0, 0, 0, "R6");
    do_buswr(1, 3, 0, 0, "R6");
    // R7 / R8 write hits
    do_wrhit(0);
    do_wrhit(0);
    do_wrhit(3);
    do_wrhit(6);
    // R9 / R10 inquires
    do_inq(0, 0, 2);
    do_inq(4, 0, 0);
    do_wrhit(1);
    do_inq(1, 1, 3);
    do_inq(3, 1, 0);
    do_inq(7, 1, 0);
    // R12 flush with modified lines
    do_fill(2, 1, 0, 0, "R2");
    do_fill(6, 1, 0, 1, "R2");
    do_wrhit(2);
    do_wrhit(6);
    do_flush();
    // empty flush
    do_flush();

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op = $urandom % 16;
      int idx = $urandom % LINES;
      if (op < 5)       do_fill(idx, 1'($urandom % 2), 1'(($urandom % 4) == 0), 1'($urandom % 2), "R2 R3 R4");
      else if (op < 7)  do_buswr(1 + ($urandom % 3), idx, 1'($urandom % 2), 1'($urandom % 2), "R5 R6");
      else if (op < 12) do_wrhit(idx);
      else if (op < 15) do_inq(idx, 1'($urandom % 2), $urandom % 4);
      else              do_flush();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule